// File: doc/BRIEF.md
# Printer-Side Parallel Capture Front End

This block sits on the printer side of a byte-wide parallel printer link. When the sender pulls its strobe low, the block stores the byte on the data lines, raises BUSY back to the sender, and signals a host through a data-ready line. The host reads the stored byte at its own pace. It then drives a falling edge on its acknowledge input. That edge starts a timed, active-low acknowledge pulse to the sender. Part way through the pulse the busy latch is released, and the sender may then present its next byte. The host also has a clear input that empties the busy latch without sending an acknowledge, for use during start-up.

All timing comes from a synchronous system clock. Cycle counters replace the analogue delays. The release point and the pulse length are parameters in clock cycles, and their defaults are worked out from a clock-frequency parameter. The sender strobe, the host acknowledge and the host clear are asynchronous, so each passes through a two-flop synchroniser. The data lines pass through one too, so they stay aligned with the strobe. The stored byte appears on plain output pins and holds still while busy is set. No handshake is added at this edge, because the link's own BUSY/acknowledge protocol already throttles the sender. A strap input selects the sense of the data-ready line so that it fits either interrupt-edge convention on the host.

Top module: `cfe_capture`

## Requirements
- R1: After system reset, `busy` is 0, `ack_n` is 1, `ack_seen` is 0, `byte_out` is 0 and `ready` is at its idle level.
- R2: Holding `strobe_n` low with `host_clr_n` high sets `busy` three clock edges later. On the edge that sets it, the synchronised value of `data_in` is stored into `byte_out`.
- R3: While `busy` stays 1, `byte_out` does not change, whatever happens on `data_in` or `strobe_n`.
- R4: A 1-to-0 transition on `host_ack_n` drives `ack_n` low for exactly `PULSE_CYCLES` clock cycles. No other cause drives `ack_n` low.
- R5: `ack_seen` is 1 for exactly the cycles in which `ack_n` is 0, so the host can read the pulse.
- R6: If `strobe_n` is high, `busy` returns to 0 exactly `CLR_CYCLES` cycles after `ack_n` falls, and `ack_n` stays low after that point.
- R7: If `strobe_n` is still low when the release point arrives, `busy` stays 1. It stays 1 after the pulse ends, until a later release point or a host clear.
- R8: While `host_clr_n` is low, `busy` is held at 0 even with `strobe_n` low, and no acknowledge pulse occurs.
- R9: With `ready_pos` = 1, `ready` equals `busy` (idle 0, 1 when a byte waits). With `ready_pos` = 0, `ready` is the inverse of `busy` (idle 1, 0 when a byte waits).
- R10: A further falling edge on `host_ack_n` while a pulse is running is ignored: the running pulse keeps its length and no second pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| data_in | input | DW | Data lines from the sender |
| strobe_n | input | 1 | Active-low sender strobe, asynchronous |
| host_ack_n | input | 1 | Host acknowledge; a falling edge starts a pulse |
| host_clr_n | input | 1 | Active-low host clear of the busy latch |
| ready_pos | input | 1 | Strap: 1 = data-ready active high, 0 = active low |
| busy | output | 1 | BUSY to the sender, 1 while a byte is held |
| ack_n | output | 1 | Active-low acknowledge pulse to the sender |
| ack_seen | output | 1 | Host-readable copy of the pulse, active high |
| ready | output | 1 | Data-ready line to the host, sense set by `ready_pos` |
| byte_out | output | DW | Stored byte |

## Verification
The hardest case to reach from the ports is a release point that falls while the sender still holds its strobe low. It needs a strobe held across the whole synchroniser delay and more than `CLR_CYCLES` cycles into the acknowledge pulse. The bench holds `strobe_n` low, issues the acknowledge, and waits for the whole pulse. It then checks that `busy` never dropped. Next it asserts the host clear with the strobe still held, which exercises the priority of the clear. A second falling acknowledge edge is placed inside a running pulse, and the bench measures the full pulse length to show that the second edge was ignored.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  // Whole clock cycles in a span of microseconds at a given clock rate.
  function automatic int unsigned cycles_of_us(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction

  // Indices into the bundled control synchroniser.
  localparam int unsigned SIG_STROBE = 0;
  localparam int unsigned SIG_ACK    = 1;
  localparam int unsigned SIG_CLR    = 2;
  localparam int unsigned SIG_COUNT  = 3;

endpackage

// File: rtl/cfe_sync.sv
module cfe_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cfe_ack_timer.sv
module cfe_ack_timer #(
  parameter int unsigned CLR_CYCLES   = 625,
  parameter int unsigned PULSE_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic clr_tick
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYCLES - 1);
  localparam logic [CW-1:0] TICK = CW'(CLR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end else if (cnt == LAST) begin
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clr_tick = running && (cnt == TICK);
endmodule

// File: rtl/cfe_busy_latch.sv
module cfe_busy_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_s,
  input  logic          clr_s,
  input  logic          clr_tick,
  input  logic [DW-1:0] data_s,
  output logic          busy,
  output logic [DW-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      byte_q <= '0;
    end else if (!clr_s) begin
      busy <= 1'b0;
    end else if (!strobe_s) begin
      if (!busy) byte_q <= data_s;
      busy <= 1'b1;
    end else if (clr_tick) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/cfe_capture.sv
module cfe_capture #(
  parameter int unsigned DW           = 8,
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned CLR_CYCLES   = cfe_pkg::cycles_of_us(CLK_HZ, 5),
  parameter int unsigned PULSE_CYCLES = cfe_pkg::cycles_of_us(CLK_HZ, 10)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_in,
  input  logic          strobe_n,
  input  logic          host_ack_n,
  input  logic          host_clr_n,
  input  logic          ready_pos,
  output logic          busy,
  output logic          ack_n,
  output logic          ack_seen,
  output logic          ready,
  output logic [DW-1:0] byte_out
);
  localparam int unsigned NS = cfe_pkg::SIG_COUNT;

  logic [NS-1:0] ctl_raw, ctl_s;
  logic [DW-1:0] data_s;
  logic          strobe_s, ack_s, clr_s, ack_prev, ack_fall;
  logic          running, clr_tick;

  always_comb begin
    ctl_raw = '1;
    ctl_raw[cfe_pkg::SIG_STROBE] = strobe_n;
    ctl_raw[cfe_pkg::SIG_ACK]    = host_ack_n;
    ctl_raw[cfe_pkg::SIG_CLR]    = host_clr_n;
  end

  cfe_sync #(.W(NS), .INIT({NS{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  cfe_sync #(.W(DW), .INIT('0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(data_in), .q(data_s)
  );

  assign strobe_s = ctl_s[cfe_pkg::SIG_STROBE];
  assign ack_s    = ctl_s[cfe_pkg::SIG_ACK];
  assign clr_s    = ctl_s[cfe_pkg::SIG_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) ack_prev <= 1'b1;
    else        ack_prev <= ack_s;
  end
  assign ack_fall = ack_prev && !ack_s;

  cfe_ack_timer #(.CLR_CYCLES(CLR_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(ack_fall), .running(running), .clr_tick(clr_tick)
  );

  cfe_busy_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s), .clr_s(clr_s),
    .clr_tick(clr_tick), .data_s(data_s), .busy(busy), .byte_q(byte_out)
  );

  assign ack_n    = !running;
  assign ack_seen = running;
  assign ready    = ready_pos ? busy : !busy;
endmodule

// File: rtl/cfe_capture_chk.sv
module cfe_capture_chk #(
  parameter int unsigned DW           = 8,
  parameter int unsigned PULSE_CYCLES = 1250
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ack_n,
  input logic [DW-1:0] byte_out,
  input logic          strobe_s,
  input logic          clr_s,
  input logic          clr_tick,
  input logic          ack_fall
);
  int unsigned low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ack_n) low_cnt <= 0;
    else                 low_cnt <= low_cnt + 1;
  end

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && !strobe_s) |=> busy); // R2

  AST_BYTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(byte_out)); // R3

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(ack_fall)); // R4

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (low_cnt < PULSE_CYCLES)); // R4

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> ($past(low_cnt) == PULSE_CYCLES - 1)); // R10

  AST_RELEASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!$past(clr_s) || ($past(strobe_s) && $past(clr_tick)))); // R7

  AST_CLR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> !busy); // R8
endmodule

bind cfe_capture cfe_capture_chk #(.DW(DW), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ack_n(ack_n), .byte_out(byte_out),
  .strobe_s(strobe_s), .clr_s(clr_s), .clr_tick(clr_tick), .ack_fall(ack_fall)
);

// File: tb/cfe_capture_test.sv
module cfe_capture_test;
  localparam int DW = 8;
  localparam int CLR = 12;
  localparam int PUL = 30;

  logic clk = 0;
  logic rst_n = 0;
  logic [DW-1:0] data_in = '0;
  logic strobe_n = 1, host_ack_n = 1, host_clr_n = 1, ready_pos = 1;
  logic busy, ack_n, ack_seen, ready;
  logic [DW-1:0] byte_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfe_capture #(.DW(DW), .CLR_CYCLES(CLR), .PULSE_CYCLES(PUL)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .strobe_n(strobe_n),
    .host_ack_n(host_ack_n), .host_clr_n(host_clr_n), .ready_pos(ready_pos),
    .busy(busy), .ack_n(ack_n), .ack_seen(ack_seen), .ready(ready), .byte_out(byte_out)
  );

  // {ready_pos, byte}
  localparam logic [DW:0] VEC [6] = '{9'h1A5, 9'h05A, 9'h100, 9'h0FF, 9'h181, 9'h03C};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_strobe(input logic [DW-1:0] b);
    @(negedge clk);
    data_in = b;
    strobe_n = 0;
    wait_n(2);
    strobe_n = 1;
    wait_n(4);
  endtask

  // Drives an acknowledge; reports cycle of busy release (-1 if none),
  // pulse length, whether ack_seen ever disagreed, optional second edge.
  task automatic do_ack(input bit second, output int t_clr, output int t_len,
                        output int mirror_bad);
    int n;
    t_clr = -1; t_len = -1; mirror_bad = 0;
    @(negedge clk);
    host_ack_n = 0;
    for (int i = 0; i < 20 && ack_n; i++) @(negedge clk);
    n = 0;
    while (!ack_n && n < 4 * PUL) begin
      if (ack_seen != !ack_n) mirror_bad = 1;
      @(negedge clk);
      n++;
      if (n == 3) host_ack_n = 1;
      if (second && n == 6) host_ack_n = 0;
      if (second && n == 8) host_ack_n = 1;
      if (!busy && t_clr < 0) t_clr = n;
    end
    t_len = n;
    if (ack_seen != !ack_n) mirror_bad = 1;
    wait_n(PUL);
    check("R10 no second pulse", ack_n, 1);
  endtask

  initial begin
    int tc, tl, mb;
    logic [DW-1:0] b;
    wait_n(3);
    check("R1 busy", busy, 0);
    check("R1 ack_n", ack_n, 1);
    check("R1 ack_seen", ack_seen, 0);
    check("R1 byte_out", byte_out, 0);
    check("R1 ready idle", ready, 0);
    rst_n = 1;
    wait_n(2);

    foreach (VEC[k]) begin
      ready_pos = VEC[k][DW];
      b = VEC[k][DW-1:0];
      wait_n(2);
      check("R9 ready idle", ready, !ready_pos);
      do_strobe(b);
      check("R2 busy set", busy, 1);
      check("R2 byte stored", byte_out, b);
      check("R9 ready active", ready, ready_pos);
      data_in = ~b;
      strobe_n = 0; wait_n(2); strobe_n = 1; wait_n(4);
      check("R3 byte frozen", byte_out, b);
      do_ack(k == 2, tc, tl, mb);
      check("R6 release cycle", tc, CLR);
      check("R4 pulse length", tl, PUL);
      check("R5 ack_seen mirror", mb, 0);
      if (k == 2) check("R10 second edge ignored", tl, PUL);
    end

    // R2 latency: busy appears on third edge after strobe
    ready_pos = 1;
    @(negedge clk); data_in = 8'h77; strobe_n = 0;
    @(negedge clk); check("R2 not yet", busy, 0);
    @(negedge clk); check("R2 not yet", busy, 0);
    @(negedge clk); check("R2 set on third edge", busy, 1);
    check("R2 byte", byte_out, 8'h77);
    // R7: strobe held low through the release point
    do_ack(0, tc, tl, mb);
    check("R7 busy kept", tc, -1);
    check("R4 pulse length held", tl, PUL);
    strobe_n = 1; wait_n(5);
    check("R7 busy still set", busy, 1);
    // R8: host clear with strobe held low
    strobe_n = 0; host_clr_n = 0;
    mb = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!ack_n) mb = 1;
    end
    check("R8 busy cleared", busy, 0);
    check("R8 no pulse", mb, 0);
    wait_n(10);
    check("R8 held clear", busy, 0);
    strobe_n = 1; wait_n(4); host_clr_n = 1; wait_n(5);
    check("R8 stays clear", busy, 0);
    check("R8 ack_n idle", ack_n, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule